// File: doc/BRIEF.md
# Three-Lane 7:1 Serial Transmitter

This block turns a 21-bit parallel word into four serial lanes. On every rising edge of a slow word clock it samples the input word. It then sends that word as three 7-bit serial data frames, one frame per lane, with each bit on a bit clock that runs seven times faster. A fourth lane carries a forwarded clock waveform. Its fixed 7-bit shape repeats once per frame, so a receiver can find frame boundaries and recover the word clock.

The two clocks are taken to be phase-aligned. The fast domain holds a free-running 7-phase counter that marks the frame. Captured words pass into the per-lane shift registers only when that counter wraps, so a frame in flight is never disturbed by a new sample. After reset, or when the active-low power-down input is released, the outputs stay low for a set number of frames to allow for the clock lock time. A valid flag then rises at a frame boundary. While power-down is held, every lane sits at 0 and all sequencing state is cleared.

Top module: `serial_tx7`

## Requirements
- R1: A word sampled on a rising edge of `slowClk` is the word carried by the first complete frame that starts after that edge, at the next wrap of the phase counter.
- R2: Lane k (k = 0, 1, 2) carries input bits 7k to 7k+6. Lane 0 has bits 0..6, lane 1 has bits 7..13, and lane 2 has bits 14..20.
- R3: Within a frame, each lane sends its highest-numbered bit in phase 0 and its lowest-numbered bit in phase 6. Each bit lasts one `fastClk` cycle.
- R4: The clock lane sends 1,1,0,0,0,1,1 in phases 0 to 6 of every valid frame.
- R5: The phase counter steps 0 to 6 and back to 0 on each `fastClk` edge. Shift registers load only on the 6-to-0 step, so a sample taken mid-frame does not change the frame in progress.
- R6: After reset release or power-down release, `txValid` stays 0 and all four lanes stay 0 for LOCK_CYCLES frames. `txValid` then rises at a frame boundary, exactly LOCK_CYCLES×7 `fastClk` edges after release.
- R7: While `pdN` is 0, all three data lanes, the clock lane and `txValid` are 0 from the next `fastClk` edge on.
- R8: Once `txValid` is 1, it stays 1 until reset or power-down.
- R9: During reset all lane outputs and `txValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slowClk | input | 1 | Word clock; the input word is sampled on its rising edge |
| fastClk | input | 1 | Bit clock, seven times the word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Active-low power-down, acted on at `fastClk` edges |
| dataIn | input | 21 | Parallel word to send |
| laneOut | output | 3 | Serial data lanes; bit k is lane k |
| clkLaneOut | output | 1 | Forwarded clock lane |
| txValid | output | 1 | High once the lock interval has ended |

## Verification
The bench keeps the default lane count, frame length and clock pattern. It shortens the lock interval to 5 frames, so the lock-wait and power-down sequences can be run several times within a short run. These include a long power-down, a one-cycle power-down and a reset release. Each release is timed edge by edge. Because words are sampled on the word clock at a phase that is not the wrap, the frame-isolation rule of R5 is tested on every frame. A receive model rebuilds each 21-bit word from the lanes and compares it with the sampled word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic load;   // move captured word into the lane shifters
    logic shift;  // advance the lane shifters by one bit
    logic clear;  // power-down: hold shifters at zero
    logic txEn;   // lock interval over, drive the lanes
  } serStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl import sertx_pkg::*; #(
  parameter int BITS        = 7,
  parameter int LOCK_CYCLES = 64,
  localparam int PW = (BITS > 1) ? $clog2(BITS) : 1,
  localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES + 1) : 1
) (
  input  logic          fastClk,
  input  logic          rstN,
  input  logic          pdN,
  output serStrobe_t    strb,
  output logic [PW-1:0] phase,
  output logic          lockDone
);

  localparam logic [PW-1:0] LAST_PHASE = PW'(BITS - 1);
  localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] lockCnt;
  logic          wrap;

  assign wrap = (phase == LAST_PHASE);

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      lockCnt  <= '0;
      lockDone <= 1'b0;
    end else if (!pdN) begin
      phase    <= '0;
      lockCnt  <= '0;
      lockDone <= 1'b0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
      if (wrap && !lockDone) begin
        if (lockCnt == LOCK_LAST) begin
          lockDone <= 1'b1;
          lockCnt  <= '0;
        end else begin
          lockCnt <= lockCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.load  = pdN & wrap;
    strb.shift = pdN & ~wrap;
    strb.clear = ~pdN;
    strb.txEn  = lockDone;
  end

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath import sertx_pkg::*; #(
  parameter int LANES = 3,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int W  = LANES * BITS,
  localparam int PW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             slowClk,
  input  logic             fastClk,
  input  logic             rstN,
  input  logic [W-1:0]     dataIn,
  input  serStrobe_t       strb,
  input  logic [PW-1:0]    phase,
  output logic [W-1:0]     capWord,
  output logic [LANES-1:0] laneOut,
  output logic             clkLaneOut
);

  // Word capture in the slow domain
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) capWord <= '0;
    else       capWord <= dataIn;
  end

  // One shift register per lane, highest bit leaves first
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BITS-1:0] shReg;
    always_ff @(posedge fastClk or negedge rstN) begin
      if (!rstN)           shReg <= '0;
      else if (strb.clear) shReg <= '0;
      else if (strb.load)  shReg <= capWord[k*BITS +: BITS];
      else if (strb.shift) shReg <= {shReg[BITS-2:0], 1'b0};
    end
    assign laneOut[k] = strb.txEn & shReg[BITS-1];
  end

  // Forwarded clock lane, indexed by frame phase
  logic [PW-1:0] patIdx;
  assign patIdx     = PW'(BITS - 1) - phase;
  assign clkLaneOut = strb.txEn & CLK_PATTERN[patIdx];

endmodule

// File: rtl/serial_tx7.sv
module serial_tx7 import sertx_pkg::*; #(
  parameter int LANES       = 3,
  parameter int BITS        = 7,
  parameter int LOCK_CYCLES = 64,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int W  = LANES * BITS,
  localparam int PW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             slowClk,
  input  logic             fastClk,
  input  logic             rstN,
  input  logic             pdN,
  input  logic [W-1:0]     dataIn,
  output logic [LANES-1:0] laneOut,
  output logic             clkLaneOut,
  output logic             txValid
);

  serStrobe_t    strb;
  logic [PW-1:0] phase;
  logic [W-1:0]  capWord;

  sertx_ctrl #(
    .BITS(BITS), .LOCK_CYCLES(LOCK_CYCLES)
  ) uCtrl (
    .fastClk(fastClk), .rstN(rstN), .pdN(pdN),
    .strb(strb), .phase(phase), .lockDone(txValid)
  );

  sertx_datapath #(
    .LANES(LANES), .BITS(BITS), .CLK_PATTERN(CLK_PATTERN)
  ) uPath (
    .slowClk(slowClk), .fastClk(fastClk), .rstN(rstN),
    .dataIn(dataIn), .strb(strb), .phase(phase),
    .capWord(capWord), .laneOut(laneOut), .clkLaneOut(clkLaneOut)
  );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int LANES = 3,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int W  = LANES * BITS,
  localparam int PW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input logic             fastClk,
  input logic             rstN,
  input logic             pdN,
  input logic [PW-1:0]    phase,
  input logic [W-1:0]     capWord,
  input logic [LANES-1:0] laneOut,
  input logic             clkLaneOut,
  input logic             txValid
);

  a_r7_idle_when_down: assert property (@(posedge fastClk) disable iff (!rstN)
    !pdN |=> (laneOut == '0 && !clkLaneOut && !txValid));

  a_r6_quiet_before_lock: assert property (@(posedge fastClk) disable iff (!rstN)
    !txValid |-> (laneOut == '0 && !clkLaneOut));

  a_r6_valid_on_boundary: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(txValid) |-> phase == '0);

  a_r8_valid_sticky: assert property (@(posedge fastClk) disable iff (!rstN)
    (txValid && pdN) |=> txValid);

  a_r5_phase_wrap: assert property (@(posedge fastClk) disable iff (!rstN)
    (phase == PW'(BITS - 1) && pdN) |=> phase == '0);

  a_r4_clk_frame_start: assert property (@(posedge fastClk) disable iff (!rstN)
    (txValid && phase == '0) |-> clkLaneOut == CLK_PATTERN[BITS-1]);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // R2 and R3: first bit of lane k is its top input bit, loaded at the wrap
    a_r3_lane_head: assert property (@(posedge fastClk) disable iff (!rstN)
      (txValid && phase == '0) |-> laneOut[k] == $past(capWord[k*BITS + BITS - 1]));
  end

endmodule

bind serial_tx7 sertx_chk #(
  .LANES(LANES), .BITS(BITS), .CLK_PATTERN(CLK_PATTERN)
) uChk (
  .fastClk(fastClk), .rstN(rstN), .pdN(pdN), .phase(phase),
  .capWord(capWord), .laneOut(laneOut), .clkLaneOut(clkLaneOut),
  .txValid(txValid)
);

// File: tb/tb_serial_tx7.sv
module tb_serial_tx7;

  localparam int LANES = 3;
  localparam int BITS  = 7;
  localparam int W     = LANES * BITS;
  localparam int LOCK  = 5;
  localparam logic [BITS-1:0] PAT = 7'b1100011;

  logic fastClk = 1'b0;
  logic slowClk = 1'b0;
  logic rstN = 1'b0;
  logic pdN  = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [LANES-1:0] laneOut;
  logic clkLaneOut;
  logic txValid;

  int total = 0;
  int bad   = 0;

  serial_tx7 #(.LANES(LANES), .BITS(BITS), .LOCK_CYCLES(LOCK), .CLK_PATTERN(PAT)) dut (
    .slowClk(slowClk), .fastClk(fastClk), .rstN(rstN), .pdN(pdN),
    .dataIn(dataIn), .laneOut(laneOut), .clkLaneOut(clkLaneOut), .txValid(txValid)
  );

  always #5 fastClk = ~fastClk;
  initial begin
    #10;
    forever begin slowClk = 1'b1; #35; slowClk = 1'b0; #35; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [W-1:0] lastCap;
  logic [W-1:0] mFrame;
  int  mPhase;
  int  mLock;
  bit  mValid;

  always @(posedge slowClk or negedge rstN) begin
    if (!rstN) lastCap <= '0;
    else       lastCap <= dataIn;
  end

  always @(posedge fastClk or negedge rstN) begin
    if (!rstN || !pdN) begin
      mPhase <= 0; mLock <= 0; mValid <= 1'b0; mFrame <= '0;
    end else if (mPhase == BITS - 1) begin
      mPhase <= 0;
      mFrame <= lastCap;
      if (!mValid) begin
        if (mLock == LOCK - 1) mValid <= 1'b1;
        else mLock <= mLock + 1;
      end
    end else begin
      mPhase <= mPhase + 1;
    end
  end

  // Per-cycle compare plus frame deserialiser
  logic [BITS-1:0] rxLane [LANES];
  int rxCnt = 0;

  always @(negedge fastClk) begin
    if (rstN) begin
      if (!mValid) begin
        check(laneOut == '0 && !clkLaneOut, pdN ? "R6" : "R7", "lanes idle",
              {28'd0, laneOut, clkLaneOut}, 32'd0);
        check(!txValid, pdN ? "R6" : "R7", "txValid low", {31'd0, txValid}, 32'd0);
        rxCnt = 0;
      end else begin
        for (int k = 0; k < LANES; k++) begin
          check(laneOut[k] == mFrame[k*BITS + BITS - 1 - mPhase], "R3", "lane bit",
                {31'd0, laneOut[k]}, {31'd0, mFrame[k*BITS + BITS - 1 - mPhase]});
        end
        check(clkLaneOut == PAT[BITS - 1 - mPhase], "R4", "clock lane",
              {31'd0, clkLaneOut}, {31'd0, PAT[BITS - 1 - mPhase]});
        check(txValid, "R8", "txValid held", {31'd0, txValid}, 32'd1);
        if (mPhase == 0) rxCnt = 0;
        for (int k = 0; k < LANES; k++) rxLane[k] = {rxLane[k][BITS-2:0], laneOut[k]};
        rxCnt++;
        if (mPhase == BITS - 1 && rxCnt == BITS) begin
          logic [W-1:0] word;
          for (int k = 0; k < LANES; k++) word[k*BITS +: BITS] = rxLane[k];
          check(word == mFrame, "R1 R2 R5", "received word", 32'(word), 32'(mFrame));
        end
      end
    end
  end

  // Word stimulus, changed on the slow falling edge
  initial begin
    int idx = 0;
    forever begin
      @(negedge slowClk);
      case (idx % 6)
        0: dataIn = W'(1) << (idx % W);
        1: dataIn = '1;
        2: dataIn = '0;
        3: dataIn = {(W+1)/2{2'b10}} [W-1:0];
        4: dataIn = W'($urandom);
        default: dataIn = ~(W'(1) << ((idx * 5) % W));
      endcase
      idx++;
    end
  end

  task automatic lockTime(input string tag);
    int cnt = 0;
    while (!txValid) begin
      @(posedge fastClk);
      cnt++;
      @(negedge fastClk);
    end
    check(cnt == LOCK * BITS, "R6", tag, 32'(cnt), 32'(LOCK * BITS));
  endtask

  initial begin
    repeat (3) @(negedge fastClk);
    check(laneOut == '0 && !clkLaneOut && !txValid, "R9", "reset state",
          {28'd0, laneOut, clkLaneOut}, 32'd0);
    rstN = 1'b1;
    lockTime("lock after reset");
    repeat (40 * BITS) @(negedge fastClk);
    pdN = 1'b0;
    repeat (3) @(negedge fastClk);
    check(laneOut == '0 && !clkLaneOut && !txValid, "R7", "power-down idle",
          {28'd0, laneOut, clkLaneOut}, 32'd0);
    repeat (15) @(negedge fastClk);
    pdN = 1'b1;
    lockTime("lock after long power-down");
    repeat (30 * BITS + 3) @(negedge fastClk);
    pdN = 1'b0;
    @(negedge fastClk);
    pdN = 1'b1;
    lockTime("lock after short power-down");
    repeat (20 * BITS) @(negedge fastClk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule